// File: doc/BRIEF.md
# Pipelined Event Counter with Coherent Snapshot

This block counts rising edges of a slow external event line that has no timing relationship to the chip clock. The event line is never used as a clock. It passes through a two-stage synchronizer into the fast internal clock domain. An edge detector then turns each low-to-high transition into a single-cycle count enable.

The count is held in half-width segments so that the carry logic stays short. The lowest segment increments on the count enable. Each higher segment increments one cycle after the segment below it wraps, driven by a registered carry. Per-segment delay registers put the segments back into step, so the aligned output always shows a value the counter really held. A capture request copies that aligned value into a holding register without pausing the count, like reading a lap time from a running stopwatch.

The count width and the segment width are parameters, with defaults of 32 and 16. The number of segments is their quotient.

Top module: `evt_lap_counter`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, `count_out` and `snap_out` read zero and `snap_vld` reads 0.
- R2: Each rising edge of `evt_in` increments `count_out` by exactly one. This holds when `evt_in` stays high for at least two clock cycles and low for at least two. With NSEG = CNT_W/SEG_W, the new value appears after the (NSEG+2)th rising clock edge that samples `evt_in` high: the 4th edge at the defaults, the 5th for three segments.
- R3: Holding `evt_in` high for many cycles, and its falling edge, cause no increment.
- R4: From one cycle to the next, `count_out` either holds or increases by exactly one modulo 2^CNT_W. This includes every carry across a segment boundary.
- R5: After the all-ones value, `count_out` wraps to all zeros, with no other value shown in between.
- R6: When `cap_req` is 1 at a clock edge, then in the following cycle `snap_out` equals the `count_out` value present at that edge, and `snap_vld` is 1. `snap_vld` is 1 only in cycles that follow such a request.
- R7: `snap_out` keeps its value in every cycle without a capture. Counting continues through captures, so no event is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal counting clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside the block |
| evt_in | input | 1 | Asynchronous external event line |
| cap_req | input | 1 | Capture request, sampled at each clock edge |
| count_out | output | CNT_W | Aligned running count |
| snap_out | output | CNT_W | Captured copy of the count |
| snap_vld | output | 1 | One-cycle flag marking a fresh capture |

## Verification
The assertions assume that `evt_in` respects the minimum high and low times of two clock cycles. Given that, the edge detector never fires on two consecutive cycles, and the aligned count can only hold or step by one. They also assume that `cap_req` is driven synchronously to `clk`. The stimulus keeps every random high and low period between two and five cycles and changes `cap_req` only away from the active edge. A second instance with three 2-bit segments wraps many times in a short run, which exercises the delayed carries across more than one boundary.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;
  // number of segments needed to cover a count of width w with segments of width s
  function automatic int unsigned seg_count(input int unsigned w, input int unsigned s);
    return (w + s - 1) / s;
  endfunction
endpackage

// File: rtl/evtc_rst_sync.sv
module evtc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/evtc_edge_sync.sv
module evtc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_async,
  output logic rise_pulse
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], evt_async};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise_pulse = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/evtc_split_counter.sv
module evtc_split_counter #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned SEG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] aligned
);
  localparam int unsigned NSEG = CNT_W / SEG_W;

  // step[k] advances segment k; step[k+1] is the registered carry out of segment k
  logic [NSEG-1:0] step;
  assign step[0] = inc;

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    localparam int unsigned DLY = NSEG - 1 - k;

    logic [SEG_W-1:0] seg_q;
    logic [SEG_W-1:0] seg_d;

    always_comb begin
      seg_d = seg_q;
      if (step[k]) seg_d = seg_q + {{(SEG_W-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seg_q <= '0;
      else        seg_q <= seg_d;
    end

    if (k < NSEG - 1) begin : g_carry
      logic carry_q;
      logic carry_d;
      always_comb begin
        carry_d = step[k] & (&seg_q);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) carry_q <= 1'b0;
        else        carry_q <= carry_d;
      end
      assign step[k+1] = carry_q;
    end

    if (DLY > 0) begin : g_align
      logic [SEG_W-1:0] dly_q [DLY];
      logic [SEG_W-1:0] dly_d [DLY];
      always_comb begin
        dly_d[0] = seg_q;
        for (int i = 1; i < DLY; i++) dly_d[i] = dly_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DLY; i++) dly_q[i] <= '0;
        end else begin
          dly_q <= dly_d;
        end
      end
      assign aligned[k*SEG_W +: SEG_W] = dly_q[DLY-1];
    end else begin : g_direct
      assign aligned[k*SEG_W +: SEG_W] = seg_q;
    end
  end
endmodule

// File: rtl/evtc_snapshot.sv
module evtc_snapshot #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_req,
  input  logic [CNT_W-1:0] live,
  output logic [CNT_W-1:0] held,
  output logic             fresh
);
  logic [CNT_W-1:0] held_q, held_d;
  logic             fresh_q, fresh_d;

  always_comb begin
    held_d  = held_q;
    fresh_d = cap_req;
    if (cap_req) held_d = live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= '0;
      fresh_q <= 1'b0;
    end else begin
      held_q  <= held_d;
      fresh_q <= fresh_d;
    end
  end

  assign held  = held_q;
  assign fresh = fresh_q;
endmodule

// File: rtl/evt_lap_counter.sv
module evt_lap_counter #(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SEG_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_in,
  input  logic             cap_req,
  output logic [CNT_W-1:0] count_out,
  output logic [CNT_W-1:0] snap_out,
  output logic             snap_vld
);
  import evt_cnt_pkg::*;

  localparam int unsigned NSEG = seg_count(CNT_W, SEG_W);
  localparam int unsigned FULL_W = NSEG * SEG_W;

  logic             rst_int_n;
  logic             edge_pulse;
  logic [FULL_W-1:0] aligned_w;

  evtc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  evtc_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .evt_async  (evt_in),
    .rise_pulse (edge_pulse)
  );

  evtc_split_counter #(.CNT_W(FULL_W), .SEG_W(SEG_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .inc     (edge_pulse),
    .aligned (aligned_w)
  );

  assign count_out = aligned_w[CNT_W-1:0];

  evtc_snapshot #(.CNT_W(CNT_W)) u_snap (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cap_req (cap_req),
    .live    (count_out),
    .held    (snap_out),
    .fresh   (snap_vld)
  );
endmodule

// File: rtl/evt_lap_counter_chk.sv
module evt_lap_counter_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inc,
  input logic             cap_req,
  input logic [CNT_W-1:0] count_out,
  input logic [CNT_W-1:0] snap_out,
  input logic             snap_vld
);
  // R3: one enable per edge, never two in a row
  a_r3_single_enable: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> !inc);

  // R4: aligned count holds or steps by one
  a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (count_out == $past(count_out)) || (count_out == CNT_W'($past(count_out) + 1'b1)));

  // R5: leaving all ones goes to zero
  a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(count_out) == {CNT_W{1'b1}}) && (count_out != $past(count_out))) |-> (count_out == '0));

  // R6: capture takes the count seen at the request edge
  a_r6_snap_value: assert property (@(posedge clk) disable iff (!rst_n)
    snap_vld |-> (snap_out == $past(count_out)));

  // R6: flag follows a request by one cycle
  a_r6_vld_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    snap_vld == $past(cap_req));

  // R7: held value is stable without a capture
  a_r7_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_vld |-> $stable(snap_out));
endmodule

bind evt_lap_counter evt_lap_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .inc       (edge_pulse),
  .cap_req   (cap_req),
  .count_out (count_out),
  .snap_out  (snap_out),
  .snap_vld  (snap_vld)
);

// File: tb/tb_evt_lap_counter.sv
module tb_evt_lap_counter;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_in = 1'b0;
  logic cap_req = 1'b0;
  logic [31:0]   count_big, snap_big;
  logic          vld_big;
  logic [SW-1:0] count_sm, snap_sm;
  logic          vld_sm;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0]   exp_big = '0;
  logic [SW-1:0] exp_sm = '0;
  bit            cap_pend = 0;
  bit            rnd_cap = 0;
  logic [31:0]   cap_big;
  logic [SW-1:0] cap_sm;
  logic [SW-1:0] mon_prev = '0;
  int            mon_err = 0;
  bit            mon_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_lap_counter dut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .cap_req(cap_req),
    .count_out(count_big), .snap_out(snap_big), .snap_vld(vld_big));

  evt_lap_counter #(.CNT_W(SW), .SEG_W(2)) dut_small (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .cap_req(cap_req),
    .count_out(count_sm), .snap_out(snap_sm), .snap_vld(vld_sm));

  function automatic logic [31:0] nxt_big(input logic [31:0] v);
    return v + 32'd1;
  endfunction

  function automatic logic [SW-1:0] nxt_sm(input logic [SW-1:0] v);
    return v + {{(SW-1){1'b0}}, 1'b1};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // R4/R5: small counter must only hold or step by one, wrap included
  always @(negedge clk) begin
    if (mon_on && count_sm != mon_prev && count_sm != nxt_sm(mon_prev)) mon_err++;
    mon_prev = count_sm;
  end

  // one cycle: check a pending capture (R6), then drive level and capture request
  task automatic step(input logic lvl);
    @(negedge clk);
    if (cap_pend) begin
      chk("R6 vld big", {31'd0, vld_big}, 32'd1);
      chk("R6 snap big", snap_big, cap_big);
      chk("R6 snap small", {{(32-SW){1'b0}}, snap_sm}, {{(32-SW){1'b0}}, cap_sm});
      cap_pend = 0;
    end
    evt_in = lvl;
    cap_req = 1'b0;
    if (rnd_cap && $urandom_range(0, 3) == 0) begin
      cap_req  = 1'b1;
      cap_pend = 1;
      cap_big  = count_big;
      cap_sm   = count_sm;
    end
  endtask

  task automatic pulse(input int hi, input int lo);
    repeat (hi) step(1'b1);
    repeat (lo) step(1'b0);
    exp_big = nxt_big(exp_big);
    exp_sm  = nxt_sm(exp_sm);
  endtask

  task automatic settle();
    repeat (8) step(1'b0);
  endtask

  task automatic chk_counts(input string tag);
    chk({tag, " big"}, count_big, exp_big);
    chk({tag, " small"}, {{(32-SW){1'b0}}, count_sm}, {{(32-SW){1'b0}}, exp_sm});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] held_big;
    void'($urandom(32'h5eed_0c17));

    // R1: reset state
    repeat (4) @(negedge clk);
    chk("R1 count", count_big, 32'd0);
    chk("R1 snap", snap_big, 32'd0);
    chk("R1 vld", {31'd0, vld_big}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 count after release", count_big, 32'd0);
    settle();
    mon_on = 1;

    // R2: latency of one edge, both variants
    step(1'b1);
    for (int i = 1; i <= 6; i++) begin
      step(i < 2 ? 1'b1 : 1'b0);
      if (i == 3) chk("R2 big before latency", count_big, 32'd0);
      if (i == 4) begin
        chk("R2 big at latency", count_big, 32'd1);
        chk("R2 small before latency", {26'd0, count_sm}, 32'd0);
      end
      if (i == 5) chk("R2 small at latency", {26'd0, count_sm}, 32'd1);
    end
    exp_big = 32'd1;
    exp_sm  = 6'd1;
    settle();

    // R3: long high level and falling edge add only one
    repeat (20) step(1'b1);
    exp_big = nxt_big(exp_big);
    exp_sm  = nxt_sm(exp_sm);
    settle();
    chk_counts("R3 long high");
    repeat (20) step(1'b0);
    chk_counts("R3 falling edge");

    // R6: idle capture
    @(negedge clk);
    cap_req = 1'b1;
    cap_pend = 1;
    cap_big = count_big;
    cap_sm = count_sm;
    step(1'b0);
    step(1'b0);
    chk("R6 vld one cycle", {31'd0, vld_big}, 32'd0);
    chk("R6 idle snap model", snap_big, exp_big);

    // R2/R7: random pulses with random captures while counting
    rnd_cap = 1;
    for (int n = 0; n < 150; n++) pulse($urandom_range(2, 5), $urandom_range(2, 5));
    rnd_cap = 0;
    settle();
    chk_counts("R7 count continues through captures");

    // R5: drive small counter to all ones, then one more edge
    while (exp_sm != {SW{1'b1}}) pulse(2, 2);
    settle();
    chk_counts("R5 at all ones");
    pulse(2, 2);
    settle();
    chk_counts("R5 wrapped");
    chk("R4/R5 no glitched step", mon_err, 0);

    // R7: snapshot holds while count moves on
    @(negedge clk);
    cap_req = 1'b1;
    cap_pend = 1;
    cap_big = count_big;
    cap_sm = count_sm;
    step(1'b0);
    held_big = exp_big;
    for (int n = 0; n < 5; n++) pulse(3, 2);
    settle();
    chk("R7 snap held", snap_big, held_big);
    chk_counts("R7 count moved");

    // R1: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    mon_on = 0;
    @(negedge clk);
    chk("R1 mid-run count", count_big, 32'd0);
    chk("R1 mid-run snap", snap_big, 32'd0);

    finish_run();
  end
endmodule